// File: doc/BRIEF.md
# Hash Accelerator Status and Interrupt Flags

This block holds the four status flags of a memory-mapped hash accelerator and drives its single interrupt line. Two flags simply report live conditions: whether the core is busy on a block, and whether the DMA path is active. The other two flags are sticky. One reports that a finished digest is available. The other reports that the input buffer has room for a whole new block. Hardware sets the sticky flags. Software clears them by writing a zero to the flag, and each is also cleared as a side effect of a write to a neighbouring register.

The block watches the shared register write port. It decodes three byte offsets: the status word, the control word (for its initialise bit) and the data-input word. It returns the status word on a combinational read port. The interrupt is a registered level. It is built from the two sticky flags, each gated by its own enable input.

Top module: `hash_status_irq`

## Requirements
- R1: While reset is asserted, and after it is released, the status word reads 0x0000_0001 (only the buffer-ready flag set) and the interrupt output is low.
- R2: Status bits 31:4 always read as zero, and writes to them have no effect. A read at any address other than the status offset 0x24 returns zero.
- R3: Bit 3 (busy) shows the core-busy input as it was sampled at the previous clock edge. Bus writes do not change it.
- R4: Bit 2 (DMA active) is high in the cycle after the DMA enable input is high. Once the enable drops, the bit stays high while the transfer-in-flight input is high. It goes low in the cycle after the enable is low and no transfer is in flight. Bus writes do not change it.
- R5: A pulse on the digest-done input sets bit 1 (digest ready) at the next clock edge.
- R6: Bit 1 is cleared by a write to offset 0x24 with data bit 1 equal to 0. It is also cleared by a write to offset 0x00 with data bit 2 (initialise) equal to 1. Writing 1 to bit 1 of the status word leaves it unchanged, and so does a write to offset 0x00 with bit 2 equal to 0.
- R7: A pulse on the block-space input sets bit 0 (buffer ready) at the next clock edge.
- R8: Bit 0 is cleared by a write to offset 0x24 with data bit 0 equal to 0, and by any write to offset 0x04. Writing 1 to bit 0 of the status word leaves it unchanged.
- R9: If a hardware set and a clear condition hit the same sticky flag in the same cycle, the flag ends up set.
- R10: The interrupt output equals, one clock later, (bit 1 AND digest enable) OR (bit 0 AND ready enable). The DMA and busy bits never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | 32 | Status word, or zero for other offsets |
| core_busy | input | 1 | Hash core is processing a block |
| dma_en | input | 1 | DMA enable from the control register |
| dma_xfer | input | 1 | A DMA transfer is still in flight |
| digest_done | input | 1 | Single-cycle pulse: digest is complete |
| blk_space | input | 1 | Single-cycle pulse: input buffer has 16 free words |
| ie_digest | input | 1 | Interrupt enable for the digest-ready flag |
| ie_ready | input | 1 | Interrupt enable for the buffer-ready flag |
| irq | output | 1 | Registered interrupt level |

## Verification
The hardest cases to reach are a set pulse and a clear write landing in the same cycle on a sticky flag, and the DMA bit outliving its enable. Random stimulus alone rarely drives the enable low while a transfer is still flagged, and keeps it that way for several cycles. Directed sequences build both situations on purpose. They pulse digest-done together with an initialise write, and block-space together with a status write of zero. They also hold the transfer input high for several cycles after the enable falls. A long random phase then mixes writes to all three decoded offsets with pulses and enable changes. A behavioural model compares every field each cycle.

// File: rtl/hash_stat_pkg.sv
package hash_stat_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned NUM_FLAGS   = 4;
  localparam int unsigned NUM_STICKY  = 2;
  localparam int unsigned IDX_READY   = 0;
  localparam int unsigned IDX_DIGEST  = 1;

  // bit order matches the read-back word: busy is bit 3, ready bit 0
  typedef struct packed {
    logic busy;
    logic dma;
    logic digest;
    logic ready;
  } stat_flags_t;
endpackage

// File: rtl/hsc_sticky_flag.sv
module hsc_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  // set dominates clear
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= RST_VAL;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hsc_dma_track.sv
module hsc_dma_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic dma_xfer,
  output logic active_o
);
  logic act_q, act_d;

  always_comb begin
    act_d = dma_en | (act_q & dma_xfer);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign active_o = act_q;
endmodule

// File: rtl/hsc_irq_gen.sv
module hsc_irq_gen #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = |(flags & enables);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/hash_status_irq.sv
module hash_status_irq
  import hash_stat_pkg::*;
#(
  parameter int unsigned     AW       = 8,
  parameter logic [AW-1:0]   STAT_OFS = 8'h24,
  parameter logic [AW-1:0]   CTRL_OFS = 8'h00,
  parameter logic [AW-1:0]   DIN_OFS  = 8'h04,
  parameter int unsigned     INIT_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          core_busy,
  input  logic          dma_en,
  input  logic          dma_xfer,
  input  logic          digest_done,
  input  logic          blk_space,
  input  logic          ie_digest,
  input  logic          ie_ready,
  output logic          irq
);
  localparam int unsigned PAD = DW - NUM_FLAGS;
  localparam logic [NUM_STICKY-1:0] STICKY_RST = NUM_STICKY'(1) << IDX_READY;

  stat_flags_t            stat_q;
  logic                   busy_q;
  logic                   dma_act;
  logic [NUM_STICKY-1:0]  sticky_q, sticky_set, sticky_clr, sticky_ie;
  logic                   wr_stat, wr_ctrl, wr_din;
  logic                   unused_wdata;

  // write decode
  always_comb begin
    wr_stat = wr_en && (wr_addr == STAT_OFS);
    wr_ctrl = wr_en && (wr_addr == CTRL_OFS);
    wr_din  = wr_en && (wr_addr == DIN_OFS);
  end

  always_comb begin
    sticky_set             = '0;
    sticky_clr             = '0;
    sticky_set[IDX_READY]  = blk_space;
    sticky_set[IDX_DIGEST] = digest_done;
    sticky_clr[IDX_READY]  = (wr_stat & ~wr_data[IDX_READY]) | wr_din;
    sticky_clr[IDX_DIGEST] = (wr_stat & ~wr_data[IDX_DIGEST]) |
                             (wr_ctrl & wr_data[INIT_BIT]);
    sticky_ie              = '0;
    sticky_ie[IDX_READY]   = ie_ready;
    sticky_ie[IDX_DIGEST]  = ie_digest;
  end

  assign unused_wdata = ^wr_data;

  generate
    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
      hsc_sticky_flag #(.RST_VAL(STICKY_RST[g])) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sticky_set[g]),
        .clr_i  (sticky_clr[g]),
        .flag_o (sticky_q[g])
      );
    end
  endgenerate

  // busy mirror register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= core_busy;
  end

  hsc_dma_track u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_en   (dma_en),
    .dma_xfer (dma_xfer),
    .active_o (dma_act)
  );

  hsc_irq_gen #(.N(NUM_STICKY)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (sticky_q),
    .enables (sticky_ie),
    .irq_o   (irq)
  );

  always_comb begin
    stat_q.busy   = busy_q;
    stat_q.dma    = dma_act;
    stat_q.digest = sticky_q[IDX_DIGEST];
    stat_q.ready  = sticky_q[IDX_READY];
  end

  always_comb begin
    if (rd_addr == STAT_OFS) rd_data = {{PAD{1'b0}}, stat_q};
    else                     rd_data = '0;
  end
endmodule

// File: rtl/hash_status_irq_chk.sv
module hash_status_irq_chk #(
  parameter int unsigned   AW       = 8,
  parameter logic [AW-1:0] STAT_OFS = 8'h24,
  parameter logic [AW-1:0] CTRL_OFS = 8'h00,
  parameter logic [AW-1:0] DIN_OFS  = 8'h04,
  parameter int unsigned   INIT_BIT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [31:0]   rd_data,
  input logic          core_busy,
  input logic          dma_en,
  input logic          dma_xfer,
  input logic          digest_done,
  input logic          blk_space,
  input logic          ie_digest,
  input logic          ie_ready,
  input logic          irq,
  input logic [3:0]    stat
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:4] == 28'd0);

  // R2
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != STAT_OFS) |-> (rd_data == 32'd0));

  // R3
  busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (stat[3] == $past(core_busy)));

  // R4
  dma_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |=> stat[2]);

  // R4
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !dma_xfer) |=> !stat[2]);

  // R5
  digest_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digest_done |=> stat[1]);

  // R6
  init_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == CTRL_OFS && wr_data[INIT_BIT] && !digest_done) |=> !stat[1]);

  // R7
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_space |=> stat[0]);

  // R8
  din_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == DIN_OFS && !blk_space) |=> !stat[0]);

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (irq == $past((stat[1] & ie_digest) | (stat[0] & ie_ready))));
endmodule

bind hash_status_irq hash_status_irq_chk #(
  .AW(AW), .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS), .DIN_OFS(DIN_OFS), .INIT_BIT(INIT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .core_busy(core_busy), .dma_en(dma_en),
  .dma_xfer(dma_xfer), .digest_done(digest_done), .blk_space(blk_space),
  .ie_digest(ie_digest), .ie_ready(ie_ready), .irq(irq), .stat(stat_q)
);

// File: tb/hash_status_irq_tb.sv
module hash_status_irq_tb;
  localparam int AW = 8;
  localparam logic [7:0] A_STAT = 8'h24, A_CTRL = 8'h00, A_DIN = 8'h04;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, core_busy, dma_en, dma_xfer, digest_done, blk_space, ie_digest, ie_ready;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic irq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hash_status_irq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .core_busy(core_busy), .dma_en(dma_en),
    .dma_xfer(dma_xfer), .digest_done(digest_done), .blk_space(blk_space),
    .ie_digest(ie_digest), .ie_ready(ie_ready), .irq(irq)
  );

  // behavioural reference
  bit m_busy, m_dma, m_dig, m_rdy, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_dma = 0; m_dig = 0; m_rdy = 1; m_irq = 0;
    end else begin
      bit clr_r, clr_d;
      m_irq  = (m_dig && ie_digest) || (m_rdy && ie_ready);
      m_busy = core_busy;
      if (dma_en) m_dma = 1;
      else if (!dma_xfer) m_dma = 0;
      clr_r = wr_en && ((wr_addr == A_STAT && !wr_data[0]) || wr_addr == A_DIN);
      clr_d = wr_en && ((wr_addr == A_STAT && !wr_data[1]) || (wr_addr == A_CTRL && wr_data[2]));
      if (blk_space) m_rdy = 1; else if (clr_r) m_rdy = 0;
      if (digest_done) m_dig = 1; else if (clr_d) m_dig = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare midway between negedge and posedge
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic [31:0] e;
      vectors++;
      e = (rd_addr == A_STAT) ? {28'd0, m_busy, m_dma, m_dig, m_rdy} : 32'd0;
      chk("R2 reserved/offset", rd_data & 32'hFFFF_FFF0, e & 32'hFFFF_FFF0);
      chk("R3 busy", {31'd0, rd_data[3]}, {31'd0, e[3]});
      chk("R4 dma", {31'd0, rd_data[2]}, {31'd0, e[2]});
      chk("R5 R6 R9 digest", {31'd0, rd_data[1]}, {31'd0, e[1]});
      chk("R7 R8 R9 ready", {31'd0, rd_data[0]}, {31'd0, e[0]});
      chk("R10 irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL all: watchdog expired, actual hung expected finished");
    summary();
    $finish;
  end

  task automatic go();
    @(negedge clk);
    wr_en = 0; digest_done = 0; blk_space = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    go();
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = A_STAT;
    core_busy = 0; dma_en = 0; dma_xfer = 0; digest_done = 0; blk_space = 0;
    ie_digest = 0; ie_ready = 0;
    repeat (3) @(negedge clk);
    #5;
    vectors++; chk("R1 reset word", rd_data, 32'h1);
    vectors++; chk("R1 reset irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    go();
    // R1 after release
    vectors++; chk("R1 after release", rd_data, 32'h1);
    // R10: enable ready interrupt
    ie_ready = 1; go(); go();
    // R8: writing ones keeps, zero clears; R2 reserved write
    wr(A_STAT, 32'hFFFF_FFFF); go();
    wr(A_STAT, 32'hFFFF_FFFE); go();
    // R7 set, R8 clear through data-input write
    blk_space = 1; go(); go();
    wr(A_DIN, 32'h1234_5678); go();
    // R9 ready set beats status clear
    blk_space = 1; wr(A_STAT, 32'h0); go();
    // R5, R6 with digest enable
    ie_digest = 1; ie_ready = 0;
    digest_done = 1; go(); go();
    wr(A_CTRL, 32'h0000_0003); go();
    wr(A_STAT, 32'h0000_0002); go();
    wr(A_CTRL, 32'h0000_0004); go();
    digest_done = 1; go();
    wr(A_STAT, 32'h0000_0001); go();
    // R9 digest set beats initialise
    digest_done = 1; wr(A_CTRL, 32'h4); go();
    wr(A_STAT, 32'h0); go();
    // R4 DMA sticky while transfer in flight
    dma_en = 1; go(); go();
    dma_xfer = 1; go();
    dma_en = 0; repeat (4) go();
    dma_xfer = 0; go(); go();
    dma_xfer = 1; repeat (3) go();
    dma_xfer = 0; go();
    // R3 busy, writes to bits 3:2 ignored
    core_busy = 1; go();
    wr(A_STAT, 32'h0000_000C); go();
    core_busy = 0; go();
    // R2 read at other offsets
    rd_addr = A_CTRL; go();
    rd_addr = 8'h25; go();
    rd_addr = A_STAT; go();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 7);
      core_busy   = $urandom_range(0, 1) == 1;
      dma_en      = $urandom_range(0, 3) == 0;
      dma_xfer    = $urandom_range(0, 2) != 0;
      digest_done = $urandom_range(0, 5) == 0;
      blk_space   = $urandom_range(0, 5) == 0;
      ie_digest   = $urandom_range(0, 3) != 0;
      ie_ready    = $urandom_range(0, 3) != 0;
      rd_addr     = ($urandom_range(0, 7) == 0) ? 8'($urandom) : A_STAT;
      wr_en       = sel < 4;
      wr_addr     = (sel == 0) ? A_STAT : (sel == 1) ? A_CTRL : (sel == 2) ? A_DIN : 8'($urandom);
      wr_data     = $urandom;
      go();
    end
    summary();
    $finish;
  end
endmodule